// File: doc/BRIEF.md
# Down-Counting Timer Channel with Two Match Points

This block is a single periodic timer channel. Once enabled, it loads a programmed reload value and counts down by one on every selected tick. When it reaches zero it loads the reload value again on the next tick and keeps running. The tick comes either from the core clock itself, with one step per cycle, or from a 1 MHz enable pulse. That pulse is generated elsewhere in the same clock domain and arrives one cycle wide.

Two match registers mark points inside each period. They may be programmed in any order. A match value that is not smaller than the reload value counts as a match at zero. Each time the count lands on a match point, the channel raises an event. At zero it also raises one if the zero-interrupt enable is set. Every event drives a one-cycle pulse, which a shared status register can collect, and inverts the interrupt line.

Software sees the live count while the channel runs. While the channel is stopped, it sees the reload value. Direct writes to the count take effect only while the channel runs. A nonzero reload written over a zero reload starts the count at once.

Top module: `dmatch_timer`

## Requirements
- R1: After reset the read-back count, the interrupt line and the event pulse are all zero.
- R2: With the tick source select low, a running count decreases by exactly one on every clock cycle.
- R3: With the tick source select high, a running count decreases by one only in cycles where the external tick input is high, and holds in all other cycles.
- R4: A tick that arrives while the count is zero loads the reload value, so the count repeats with a period of reload+1 ticks.
- R5: When a tick brings the count to a nonzero effective match value, the event output is high for exactly that one cycle, in the same cycle the count shows that value.
- R6: Both match points produce events whichever of the two match registers holds the larger value.
- R7: A match register holding a value greater than or equal to the reload value acts as a match at zero and produces an event when the count reaches zero.
- R8: When a tick brings the count to zero, an event fires if the zero-interrupt enable is set or if either effective match value is zero, and not otherwise.
- R9: The interrupt line inverts in exactly the cycles where the event output is high and holds its level otherwise.
- R10: While the channel is disabled, the read-back count equals the reload register, including a reload written during that time.
- R11: A count write while running replaces the count on the next cycle. A count write while disabled has no effect, so the next enable still starts from the reload value.
- R12: If the reload register holds zero and a nonzero reload is written while running, the count takes that new value on the next cycle and counts down from it.
- R13: Raising the enable loads the reload value into the count one cycle later. While the enable is low the count does not change and no event fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_tick | input | 1 | One-cycle 1 MHz tick pulse |
| ctl_enable | input | 1 | Channel run enable |
| ctl_ext_sel | input | 1 | Tick source: 1 = ext_tick, 0 = every clock cycle |
| ctl_zero_irq_en | input | 1 | Raise an event when the count reaches zero |
| wr_count | input | 1 | Write strobe for the live count |
| wr_reload | input | 1 | Write strobe for the reload register |
| wr_match_a | input | 1 | Write strobe for match register A |
| wr_match_b | input | 1 | Write strobe for match register B |
| wr_data | input | CNT_W | Write data for all strobes |
| count_rd | output | CNT_W | Live count while running, reload while stopped |
| irq_lvl | output | 1 | Interrupt line that inverts on each event |
| event_pulse | output | 1 | One-cycle pulse per event |

## Verification
After the reset input goes high, the internal reset releases two edges later. From then on, every result appears at the first rising edge after the stimulus that caused it. A write strobe or an enable change is visible in count_rd after that edge. A tick changes the count at that same edge, and any event pulse and interrupt inversion it causes appear together with the new count value. The bench drives inputs on the falling edge and predicts the outcome of the following rising edge. It stamps each prediction with the cycle number at which it is due. The monitor compares predictions only at the falling edge of exactly that cycle.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  typedef enum logic {
    SRC_BUS = 1'b0,
    SRC_EXT = 1'b1
  } tick_src_e;

  localparam int unsigned NUM_MATCH = 2;
endpackage

// File: rtl/dmt_rst_sync.sv
module dmt_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sr_q <= 2'b00;
    else              sr_q <= {sr_q[0], 1'b1};
  end

  assign rst_n_sync = sr_q[1];
endmodule

// File: rtl/dmt_tick_sel.sv
module dmt_tick_sel
  import dmt_pkg::*;
(
  input  tick_src_e src_i,
  input  logic      ext_tick_i,
  output logic      tick_o
);
  always_comb begin
    unique case (src_i)
      SRC_EXT: tick_o = ext_tick_i;
      default: tick_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/dmt_counter.sv
module dmt_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             wr_count_i,
  input  logic             wr_reload_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] reload_o,
  output logic [CNT_W-1:0] dec_val_o,
  output logic             step_o,
  output logic             active_o,
  output logic [CNT_W-1:0] rd_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic             en_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] reload_q;
  logic             cnt_ld;
  logic             start;
  logic             active;
  logic             reload_gap;
  logic [CNT_W-1:0] dec_val;

  always_comb begin
    active     = en_i && en_q;
    start      = en_i && !en_q;
    reload_gap = wr_reload_i && (reload_q == ZERO) && (wr_data_i != ZERO);
    dec_val    = cnt_q - ONE;
    cnt_d      = cnt_q;
    cnt_ld     = 1'b0;
    if (start) begin
      cnt_d  = reload_q;
      cnt_ld = 1'b1;
    end else if (active) begin
      if (wr_count_i || reload_gap) begin
        cnt_d  = wr_data_i;
        cnt_ld = 1'b1;
      end else if (tick_i) begin
        cnt_d  = (cnt_q == ZERO) ? reload_q : dec_val;
        cnt_ld = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= ZERO;
    else if (cnt_ld) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           reload_q <= ZERO;
    else if (wr_reload_i) reload_q <= wr_data_i;
  end

  assign step_o    = active && !wr_count_i && !reload_gap && tick_i && (cnt_q != ZERO);
  assign dec_val_o = dec_val;
  assign reload_o  = reload_q;
  assign active_o  = active;
  assign rd_o      = en_q ? cnt_q : reload_q;

  // R13
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(cnt_q));

  // R2
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_o |=> (cnt_q == $past(cnt_q) - ONE));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && en_q && tick_i && !wr_count_i && !wr_reload_i && cnt_q == ZERO)
      |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/dmt_match.sv
module dmt_match #(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned NUM_MATCH = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_MATCH-1:0] wr_match_i,
  input  logic [CNT_W-1:0]     wr_data_i,
  input  logic [CNT_W-1:0]     reload_i,
  input  logic                 zero_en_i,
  input  logic [CNT_W-1:0]     probe_i,
  output logic                 hit_o
);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [NUM_MATCH-1:0] eq_v;
  logic [NUM_MATCH-1:0] at_zero_v;

  for (genvar g = 0; g < NUM_MATCH; g++) begin : g_pt
    logic [CNT_W-1:0] m_q;
    logic [CNT_W-1:0] eff;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             m_q <= ZERO;
      else if (wr_match_i[g]) m_q <= wr_data_i;
    end

    always_comb begin
      eff          = (m_q < reload_i) ? m_q : ZERO;
      eq_v[g]      = (probe_i == eff);
      at_zero_v[g] = (eff == ZERO);
    end
  end

  always_comb begin
    if (probe_i == ZERO) hit_o = zero_en_i || (|at_zero_v);
    else                 hit_o = |eq_v;
  end
endmodule

// File: rtl/dmt_irq.sv
module dmt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic hit_i,
  input  logic active_i,
  output logic event_o,
  output logic irq_o
);
  logic fire;
  logic evt_q, evt_d;
  logic irq_q, irq_d;

  always_comb begin
    fire  = step_i && hit_i;
    evt_d = fire;
    irq_d = irq_q ^ fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      evt_q <= evt_d;
      irq_q <= irq_d;
    end
  end

  assign event_o = evt_q;
  assign irq_o   = irq_q;

  // R9
  irq_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> (irq_o != $past(irq_o)));

  // R9
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !event_o |-> $stable(irq_o));

  // R13
  evt_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    event_o |-> $past(active_i));
endmodule

// File: rtl/dmatch_timer.sv
module dmatch_timer
  import dmt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_tick,
  input  logic             ctl_enable,
  input  logic             ctl_ext_sel,
  input  logic             ctl_zero_irq_en,
  input  logic             wr_count,
  input  logic             wr_reload,
  input  logic             wr_match_a,
  input  logic             wr_match_b,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_rd,
  output logic             irq_lvl,
  output logic             event_pulse
);
  logic                 rst_n_s;
  logic                 tick;
  tick_src_e            src;
  logic [CNT_W-1:0]     reload_q;
  logic [CNT_W-1:0]     dec_val;
  logic                 step;
  logic                 active;
  logic                 hit;
  logic [NUM_MATCH-1:0] wr_match;

  assign src      = ctl_ext_sel ? SRC_EXT : SRC_BUS;
  assign wr_match = {wr_match_b, wr_match_a};

  dmt_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  dmt_tick_sel u_tick (
    .src_i      (src),
    .ext_tick_i (ext_tick),
    .tick_o     (tick)
  );

  dmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .en_i        (ctl_enable),
    .tick_i      (tick),
    .wr_count_i  (wr_count),
    .wr_reload_i (wr_reload),
    .wr_data_i   (wr_data),
    .reload_o    (reload_q),
    .dec_val_o   (dec_val),
    .step_o      (step),
    .active_o    (active),
    .rd_o        (count_rd)
  );

  dmt_match #(.CNT_W(CNT_W), .NUM_MATCH(NUM_MATCH)) u_match (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_match_i (wr_match),
    .wr_data_i  (wr_data),
    .reload_i   (reload_q),
    .zero_en_i  (ctl_zero_irq_en),
    .probe_i    (dec_val),
    .hit_o      (hit)
  );

  dmt_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .step_i   (step),
    .hit_i    (hit),
    .active_i (active),
    .event_o  (event_pulse),
    .irq_o    (irq_lvl)
  );
endmodule

// File: tb/dmatch_timer_tb.sv
module dmatch_timer_tb;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic         ext_tick = 1'b0, en = 1'b0, xsel = 1'b0, zen = 1'b0;
  logic         wc = 1'b0, wr = 1'b0, wa = 1'b0, wb = 1'b0;
  logic [W-1:0] wd = '0;
  logic [W-1:0] count_rd;
  logic         irq_lvl, event_pulse;

  dmatch_timer #(.CNT_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick), .ctl_enable(en),
    .ctl_ext_sel(xsel), .ctl_zero_irq_en(zen), .wr_count(wc),
    .wr_reload(wr), .wr_match_a(wa), .wr_match_b(wb), .wr_data(wd),
    .count_rd(count_rd), .irq_lvl(irq_lvl), .event_pulse(event_pulse)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  int           q_cyc[$];
  logic [W-1:0] q_cnt[$];
  bit           q_evt[$];
  bit           q_irq[$];
  string        q_tag[$];

  // bench-side expectation state
  bit           m_enq = 0, m_irq = 0;
  logic [W-1:0] m_cnt = '0, m_rel = '0, m_ma = '0, m_mb = '0;

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // match point per requirements R5, R7, R8
  function automatic bit point_hit(input logic [W-1:0] v);
    logic [W-1:0] ea, eb;
    ea = (m_ma < m_rel) ? m_ma : '0;
    eb = (m_mb < m_rel) ? m_mb : '0;
    if (v == '0) return zen || (ea == '0) || (eb == '0);
    return (v == ea) || (v == eb);
  endfunction

  // driver: predict the result of the coming edge, queue it, advance one cycle
  task automatic step(input bit tk, input string tag);
    logic [W-1:0] nc;
    bit           ev;
    bit           act;
    bit           tick;
    ext_tick = tk;
    act  = en && m_enq;
    tick = xsel ? tk : 1'b1;
    nc = m_cnt;
    ev = 0;
    if (en && !m_enq) nc = m_rel;
    else if (act) begin
      if (wc) nc = wd;
      else if (wr && m_rel == '0 && wd != '0) nc = wd;
      else if (tick) begin
        if (m_cnt == '0) nc = m_rel;
        else begin
          nc = m_cnt - 1;
          ev = point_hit(nc);
        end
      end
    end
    if (wr) m_rel = wd;
    if (wa) m_ma = wd;
    if (wb) m_mb = wd;
    m_enq = en;
    m_cnt = nc;
    m_irq = m_irq ^ ev;
    q_cyc.push_back(cyc + 1);
    q_cnt.push_back(m_enq ? m_cnt : m_rel);
    q_evt.push_back(ev);
    q_irq.push_back(m_irq);
    q_tag.push_back(tag);
    @(negedge clk);
    wc = 0; wr = 0; wa = 0; wb = 0; ext_tick = 0;
  endtask

  // monitor: compare each queued item at its due cycle
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
      if (q_cyc[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed item actual=%0d expected=%0d", q_tag[0], cyc, q_cyc[0]);
      end else begin
        chk(q_tag[0], "count_rd", count_rd, q_cnt[0]);
        chk(q_tag[0], "event_pulse", W'(event_pulse), W'(q_evt[0]));
        chk(q_tag[0], "irq_lvl", W'(irq_lvl), W'(q_irq[0]));
      end
      void'(q_cyc.pop_front()); void'(q_cnt.pop_front()); void'(q_evt.pop_front());
      void'(q_irq.pop_front()); void'(q_tag.pop_front());
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1", "count_rd", count_rd, '0);
    chk("R1", "irq_lvl", W'(irq_lvl), '0);
    chk("R1", "event_pulse", W'(event_pulse), '0);

    // program while stopped: reload 12, matches 8 and 3
    wr = 1; wd = 12; step(0, "R10");
    wa = 1; wd = 8;  step(0, "R10");
    wb = 1; wd = 3;  step(0, "R10");
    en = 1; step(0, "R13");
    repeat (13) step(0, "R2");
    repeat (2)  step(0, "R4");
    repeat (14) step(0, "R8");
    repeat (13) step(0, "R9");

    // swapped order of the two match values
    en = 0; step(0, "R13");
    wa = 1; wd = 3; step(0, "R6");
    wb = 1; wd = 8; step(0, "R6");
    en = 1; repeat (28) step(0, "R6");

    // a match at or above reload acts at zero
    en = 0; step(0, "R13");
    wa = 1; wd = 20; step(0, "R7");
    wb = 1; wd = 5;  step(0, "R7");
    en = 1; repeat (28) step(0, "R7");

    // zero interrupt enable with matches 8 and 3
    en = 0; step(0, "R13");
    zen = 1;
    wa = 1; wd = 8; step(0, "R8");
    wb = 1; wd = 3; step(0, "R8");
    en = 1; repeat (28) step(0, "R8");

    // external tick source
    en = 0; zen = 0; xsel = 1; step(0, "R13");
    en = 1; step(0, "R13");
    for (int i = 0; i < 64; i++) step((i % 4) == 3, "R3");

    // direct count writes, running then stopped
    wc = 1; wd = 5; step(0, "R11");
    for (int i = 0; i < 12; i++) step((i % 3) == 2, "R11");
    en = 0; step(0, "R11");
    wc = 1; wd = 2; step(0, "R11");
    en = 1; repeat (4) step(0, "R11");

    // reload from zero while running
    xsel = 0; en = 0; step(0, "R12");
    wr = 1; wd = 0; step(0, "R12");
    en = 1; repeat (3) step(0, "R12");
    wr = 1; wd = 9; step(0, "R12");
    repeat (14) step(0, "R12");

    // stopped: reload write visible, no events
    en = 0; step(0, "R13");
    wr = 1; wd = 40; step(0, "R10");
    repeat (10) step(0, "R13");

    repeat (3) @(negedge clk);
    if (q_cyc.size() != 0) begin
      checks++; errors++;
      $display("FAIL queue actual=%0d expected=0", q_cyc.size());
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule